// File: doc/BRIEF.md
# I3C Target Dynamic Address and Common Command Engine

This block is the target-side control logic of an I3C device that sits behind a byte-level bus front end. The front end hands it decoded bus events as single-cycle pulses: a header (START or repeated START) carrying a 7-bit address and a direction bit, a byte written by the controller, a request for a byte to be read, and a STOP. For every event the block answers exactly one cycle later with an acknowledge decision and, for reads, a data byte.

The block holds the device's dynamic address and runs all of its life cycle. It takes part in the dynamic address assignment procedure while it still has no address, and answers that procedure with its provisional ID, bus characteristics byte and device characteristics byte. It also handles the commands that clear the address, copy it from the static address, or replace it with a new value. It also answers the identity queries. Framing state records whether the current header was the broadcast address, whether a command code has been captured, and whether address assignment is in progress.

The static address, provisional ID, bus characteristics and device characteristics are parameters. A variant without a static address is selected by a parameter.

Top module: `ccc_target_engine`

## Requirements
- R1: A non-broadcast header is acknowledged only when its address equals the dynamic address if that is nonzero, or else the static address; once a dynamic address exists the static address is no longer recognised.
- R2: A header to broadcast address 0x7E is acknowledged outside address assignment, and the first byte written after it is taken as the command code; codes with bit 7 set are direct commands.
- R3: While address assignment (code 0x07) is active, only 0x7E headers are acknowledged, and only while the dynamic address is zero; any other header address is not acknowledged.
- R4: Reads during address assignment return the 48-bit provisional ID as six bytes, least significant first, then the bus characteristics byte, then the device characteristics byte; further reads return 0xFF.
- R5: After those eight bytes, the next written byte supplies the new dynamic address in bits 6:0 (bit 7 ignored); later 0x7E headers in the same assignment are then not acknowledged.
- R6: Broadcast code 0x06 clears the dynamic address; broadcast code 0x29 loads it from the static address.
- R7: Direct code 0x87 loads the dynamic address from the static address on the next data byte to the selected target; direct code 0x88 loads bits 6:0 of that data byte as the dynamic address.
- R8: Direct code 0x8D reads return the six provisional ID bytes least significant first, then 0xFF; direct code 0x8E returns the bus characteristics byte and 0x8F the device characteristics byte.
- R9: Address assignment persists across repeated STARTs until STOP; any other command persists across a repeated START to a direct address but ends at a repeated START to 0x7E; STOP ends every command.
- R10: A data byte of an unsupported direct command is not acknowledged; every byte written in a broadcast frame by a selected target is acknowledged.
- R11: A read returns 0xFF when the target is not selected, the frame direction is write, or no supported command is active; an unsupported command leaves the dynamic address unchanged.
- R12: After reset the dynamic address is zero and no response is flagged; each event produces exactly one response flag in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Header event pulse (START or repeated START) |
| ev_write | input | 1 | Written byte event pulse |
| ev_read | input | 1 | Read byte request pulse |
| ev_stop | input | 1 | STOP event pulse |
| ev_addr | input | 7 | Header address, valid with ev_start |
| ev_rnw | input | 1 | Header direction, 1 for read, valid with ev_start |
| ev_data | input | 8 | Written byte, valid with ev_write |
| rsp_valid | output | 1 | Response for the previous cycle's event |
| rsp_ack | output | 1 | Acknowledge decision for header or written byte |
| rsp_data | output | 8 | Read data byte, 0xFF when nothing to return |
| dyn_addr | output | 7 | Current dynamic address, zero when unassigned |
| dyn_valid | output | 1 | Dynamic address is nonzero |

## Verification
The assertions take for granted that the front end raises at most one event pulse in any cycle and that ev_addr and ev_data are meaningful only alongside their pulse; the one-event rule is itself checked. The stimulus drives every event through one task that raises a single pulse for one cycle and lowers it before the next, so events never overlap. Random new addresses are drawn from 0x01 to 0x7D, which keeps them off the broadcast address, and random probe headers also skip 0x7E so that the match expectation stays a plain equality.

// File: rtl/ccc_tgt_pkg.sv
package ccc_tgt_pkg;
   localparam int ADDR_W = 7;
   localparam int BYTE_W = 8;
   localparam logic [ADDR_W-1:0] BCAST_ADDR = 7'h7E;

   localparam logic [BYTE_W-1:0] CODE_DAA_ENTER = 8'h07;
   localparam logic [BYTE_W-1:0] CODE_ADDR_CLR  = 8'h06;
   localparam logic [BYTE_W-1:0] CODE_ALL_STAT  = 8'h29;
   localparam logic [BYTE_W-1:0] CODE_ONE_STAT  = 8'h87;
   localparam logic [BYTE_W-1:0] CODE_NEW_ADDR  = 8'h88;
   localparam logic [BYTE_W-1:0] CODE_GET_ID    = 8'h8D;
   localparam logic [BYTE_W-1:0] CODE_GET_BCHR  = 8'h8E;
   localparam logic [BYTE_W-1:0] CODE_GET_DCHR  = 8'h8F;

   localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;

   function automatic logic code_is_direct(input logic [BYTE_W-1:0] code);
      return code[BYTE_W-1];
   endfunction
endpackage

// File: rtl/ccc_tgt_addr_match.sv
module ccc_tgt_addr_match
   import ccc_tgt_pkg::*;
#(
   parameter bit HAS_STATIC = 1'b1,
   parameter logic [ADDR_W-1:0] STATIC_ADDR = 7'h2A
) (
   input  logic [ADDR_W-1:0] hdr_addr,
   input  logic [ADDR_W-1:0] dyn_addr,
   input  logic              daa_active,
   output logic              hit
);
   logic              own_ok;
   logic [ADDR_W-1:0] own_addr;
   logic              is_bcast;
   logic              no_dyn;

   assign is_bcast = (hdr_addr == BCAST_ADDR);
   assign no_dyn   = (dyn_addr == '0);

   generate
      if (HAS_STATIC) begin : g_static
         assign own_addr = no_dyn ? STATIC_ADDR : dyn_addr;
         assign own_ok   = 1'b1;
      end else begin : g_dyn_only
         assign own_addr = dyn_addr;
         assign own_ok   = !no_dyn;
      end
   endgenerate

   always_comb begin
      if (daa_active) hit = is_bcast && no_dyn;
      else            hit = is_bcast || (own_ok && (hdr_addr == own_addr));
   end
endmodule

// File: rtl/ccc_tgt_rdmux.sv
module ccc_tgt_rdmux
   import ccc_tgt_pkg::*;
#(
   parameter int PID_BYTES = 6,
   parameter logic [8*PID_BYTES-1:0] PID = '0,
   parameter logic [BYTE_W-1:0] BCHR = 8'h00,
   parameter logic [BYTE_W-1:0] DCHR = 8'h00,
   parameter int OFS_W = 4
) (
   input  logic              active,
   input  logic [BYTE_W-1:0] code,
   input  logic [OFS_W-1:0]  ofs,
   output logic [BYTE_W-1:0] rdata,
   output logic              step
);
   localparam int DAA_LAST = PID_BYTES + 2;

   logic              in_id;
   logic [BYTE_W-1:0] id_byte;

   assign in_id   = (int'(ofs) < PID_BYTES);
   assign id_byte = in_id ? PID[8*int'(ofs) +: 8] : IDLE_BYTE;

   always_comb begin
      rdata = IDLE_BYTE;
      step  = 1'b0;
      if (active) begin
         case (code)
            CODE_DAA_ENTER: begin
               if (in_id)                            rdata = id_byte;
               else if (int'(ofs) == PID_BYTES)      rdata = BCHR;
               else if (int'(ofs) == PID_BYTES + 1)  rdata = DCHR;
               step = (int'(ofs) < DAA_LAST);
            end
            CODE_GET_ID: begin
               rdata = id_byte;
               step  = in_id;
            end
            CODE_GET_BCHR: rdata = BCHR;
            CODE_GET_DCHR: rdata = DCHR;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/ccc_target_engine.sv
module ccc_target_engine
   import ccc_tgt_pkg::*;
#(
   parameter bit HAS_STATIC = 1'b1,
   parameter logic [6:0] STATIC_ADDR = 7'h2A,
   parameter int PID_BYTES = 6,
   parameter logic [8*PID_BYTES-1:0] PID = 48'h0123_4567_89AB,
   parameter logic [7:0] BCHR = 8'h26,
   parameter logic [7:0] DCHR = 8'hC5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ev_start,
   input  logic       ev_write,
   input  logic       ev_read,
   input  logic       ev_stop,
   input  logic [6:0] ev_addr,
   input  logic       ev_rnw,
   input  logic [7:0] ev_data,
   output logic       rsp_valid,
   output logic       rsp_ack,
   output logic [7:0] rsp_data,
   output logic [6:0] dyn_addr,
   output logic       dyn_valid
);
   localparam int OFS_W    = $clog2(PID_BYTES + 3);
   localparam int DAA_LAST = PID_BYTES + 2;

   generate
      if (PID_BYTES < 1 || PID_BYTES > 8) begin : g_bad_pid
         $error("PID_BYTES must lie in 1..8");
      end
      if (HAS_STATIC && (STATIC_ADDR == BCAST_ADDR || STATIC_ADDR == 7'h00)) begin : g_bad_stat
         $error("STATIC_ADDR must be neither zero nor broadcast");
      end
   endgenerate

   logic [ADDR_W-1:0] dyn_q, dyn_d;
   logic              sel_q, sel_d;
   logic              bcast_q, bcast_d;
   logic              rdfr_q, rdfr_d;
   logic              in_ccc_q, in_ccc_d;
   logic              in_daa_q, in_daa_d;
   logic [BYTE_W-1:0] code_q, code_d;
   logic [OFS_W-1:0]  ofs_q, ofs_d;
   logic              ack_d;
   logic [BYTE_W-1:0] data_d;

   logic              hdr_hit;
   logic [BYTE_W-1:0] rd_byte;
   logic              rd_step;

   ccc_tgt_addr_match #(
      .HAS_STATIC (HAS_STATIC),
      .STATIC_ADDR(STATIC_ADDR)
   ) u_match (
      .hdr_addr  (ev_addr),
      .dyn_addr  (dyn_q),
      .daa_active(in_daa_q),
      .hit       (hdr_hit)
   );

   ccc_tgt_rdmux #(
      .PID_BYTES(PID_BYTES),
      .PID      (PID),
      .BCHR     (BCHR),
      .DCHR     (DCHR),
      .OFS_W    (OFS_W)
   ) u_rdmux (
      .active(sel_q && rdfr_q && in_ccc_q),
      .code  (code_q),
      .ofs   (ofs_q),
      .rdata (rd_byte),
      .step  (rd_step)
   );

   always_comb begin
      dyn_d    = dyn_q;
      sel_d    = sel_q;
      bcast_d  = bcast_q;
      rdfr_d   = rdfr_q;
      in_ccc_d = in_ccc_q;
      in_daa_d = in_daa_q;
      code_d   = code_q;
      ofs_d    = ofs_q;
      ack_d    = 1'b0;
      data_d   = IDLE_BYTE;

      if (ev_stop) begin
         sel_d    = 1'b0;
         bcast_d  = 1'b0;
         rdfr_d   = 1'b0;
         in_ccc_d = 1'b0;
         in_daa_d = 1'b0;
         code_d   = '0;
         ofs_d    = '0;
         ack_d    = 1'b1;
      end else if (ev_start) begin
         bcast_d = (ev_addr == BCAST_ADDR);
         if (bcast_d && !in_daa_q) in_ccc_d = 1'b0;
         sel_d  = hdr_hit;
         rdfr_d = ev_rnw;
         ack_d  = hdr_hit;
      end else if (ev_write) begin
         if (!sel_q) begin
            ack_d = 1'b0;
         end else if (bcast_q && !in_ccc_q) begin
            code_d   = ev_data;
            in_ccc_d = 1'b1;
            ofs_d    = '0;
            ack_d    = 1'b1;
            if (ev_data == CODE_DAA_ENTER) in_daa_d = 1'b1;
            if (ev_data == CODE_ADDR_CLR)  dyn_d = '0;
            if (ev_data == CODE_ALL_STAT && HAS_STATIC) dyn_d = STATIC_ADDR;
         end else if (in_ccc_q) begin
            ack_d = 1'b1;
            case (code_q)
               CODE_DAA_ENTER: begin
                  if (ofs_q == OFS_W'(DAA_LAST)) begin
                     dyn_d = ev_data[ADDR_W-1:0];
                     ofs_d = '0;
                  end
               end
               CODE_NEW_ADDR: dyn_d = ev_data[ADDR_W-1:0];
               CODE_ONE_STAT: begin
                  if (HAS_STATIC) dyn_d = STATIC_ADDR;
                  else            ack_d = bcast_q;
               end
               CODE_ADDR_CLR, CODE_ALL_STAT,
               CODE_GET_ID, CODE_GET_BCHR, CODE_GET_DCHR: ;
               default: ack_d = bcast_q || !code_is_direct(code_q);
            endcase
         end else begin
            ack_d = 1'b1;
         end
      end else if (ev_read) begin
         data_d = rd_byte;
         ack_d  = sel_q;
         if (rd_step) ofs_d = ofs_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dyn_q     <= '0;
         sel_q     <= 1'b0;
         bcast_q   <= 1'b0;
         rdfr_q    <= 1'b0;
         in_ccc_q  <= 1'b0;
         in_daa_q  <= 1'b0;
         code_q    <= '0;
         ofs_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_ack   <= 1'b0;
         rsp_data  <= IDLE_BYTE;
      end else begin
         dyn_q     <= dyn_d;
         sel_q     <= sel_d;
         bcast_q   <= bcast_d;
         rdfr_q    <= rdfr_d;
         in_ccc_q  <= in_ccc_d;
         in_daa_q  <= in_daa_d;
         code_q    <= code_d;
         ofs_q     <= ofs_d;
         rsp_valid <= ev_start | ev_write | ev_read | ev_stop;
         rsp_ack   <= ack_d;
         rsp_data  <= data_d;
      end
   end

   assign dyn_addr  = dyn_q;
   assign dyn_valid = (dyn_q != '0);
endmodule

// File: rtl/ccc_target_engine_chk.sv
module ccc_target_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ev_start,
   input logic       ev_write,
   input logic       ev_read,
   input logic       ev_stop,
   input logic [6:0] ev_addr,
   input logic [7:0] ev_data,
   input logic       rsp_valid,
   input logic       rsp_ack,
   input logic [7:0] rsp_data,
   input logic [6:0] dyn_addr,
   input logic       sel,
   input logic       bcast,
   input logic       in_ccc,
   input logic       in_daa
);
   logic ev_any;
   assign ev_any = ev_start | ev_write | ev_read | ev_stop;

   p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_start, ev_write, ev_read, ev_stop}));

   p_rsp_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev_any |=> rsp_valid);

   p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_any |=> !rsp_valid);

   p_dyn_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && !in_daa && ev_addr != 7'h7E && dyn_addr != 7'h00 && ev_addr != dyn_addr)
      |=> !rsp_ack);

   p_daa_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start && in_daa && ev_addr != 7'h7E) |=> !rsp_ack);

   p_addr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_write && sel && bcast && !in_ccc && ev_data == 8'h06) |=> (dyn_addr == 7'h00));

   p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (!in_ccc && !in_daa && !sel));

   p_bcast_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_write && sel && bcast) |=> rsp_ack);

   p_unsel_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_read && !sel) |=> (rsp_data == 8'hFF));
endmodule

bind ccc_target_engine ccc_target_engine_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ev_start (ev_start),
   .ev_write (ev_write),
   .ev_read  (ev_read),
   .ev_stop  (ev_stop),
   .ev_addr  (ev_addr),
   .ev_data  (ev_data),
   .rsp_valid(rsp_valid),
   .rsp_ack  (rsp_ack),
   .rsp_data (rsp_data),
   .dyn_addr (dyn_addr),
   .sel      (sel_q),
   .bcast    (bcast_q),
   .in_ccc   (in_ccc_q),
   .in_daa   (in_daa_q)
);

// File: tb/ccc_target_engine_bench.sv
`timescale 1ns/1ps
module ccc_target_engine_bench;
   localparam logic [6:0]  STAT = 7'h2A;
   localparam logic [47:0] PIDV = 48'h0123_4567_89AB;
   localparam logic [7:0]  BCV  = 8'h26;
   localparam logic [7:0]  DCV  = 8'hC5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0, ev_write = 1'b0, ev_read = 1'b0, ev_stop = 1'b0;
   logic [6:0] ev_addr = '0;
   logic       ev_rnw = 1'b0;
   logic [7:0] ev_data = '0;
   logic       rsp_valid, rsp_ack, dyn_valid;
   logic [7:0] rsp_data;
   logic [6:0] dyn_addr;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   ccc_target_engine #(
      .STATIC_ADDR(STAT), .PID(PIDV), .BCHR(BCV), .DCHR(DCV)
   ) u_ccc_target_engine (
      .clk(clk), .rst_n(rst_n),
      .ev_start(ev_start), .ev_write(ev_write), .ev_read(ev_read), .ev_stop(ev_stop),
      .ev_addr(ev_addr), .ev_rnw(ev_rnw), .ev_data(ev_data),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
      .dyn_addr(dyn_addr), .dyn_valid(dyn_valid)
   );

   function automatic logic [7:0] pid_byte(input int i);
      return PIDV[8*i +: 8];
   endfunction

   function automatic logic exp_hit(input logic [6:0] probe, input logic [6:0] cur);
      logic [6:0] own;
      own = (cur != 7'h00) ? cur : STAT;
      return (probe == 7'h7E) || (probe == own);
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hdr(input logic [6:0] a, input logic rnw, output logic ack);
      @(negedge clk); ev_start = 1'b1; ev_addr = a; ev_rnw = rnw;
      @(negedge clk); ev_start = 1'b0; ack = rsp_ack;
   endtask

   task automatic wr(input logic [7:0] d, output logic ack);
      @(negedge clk); ev_write = 1'b1; ev_data = d;
      @(negedge clk); ev_write = 1'b0; ack = rsp_ack;
   endtask

   task automatic rd(output logic [7:0] d);
      @(negedge clk); ev_read = 1'b1;
      @(negedge clk); ev_read = 1'b0; d = rsp_data;
   endtask

   task automatic stp();
      @(negedge clk); ev_stop = 1'b1;
      @(negedge clk); ev_stop = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      logic [6:0] cur;
      int unsigned seed;
      seed = 32'h1234_5678;
      void'($urandom(seed));

      repeat (3) @(negedge clk);
      check("R12 reset rsp_valid", rsp_valid, 0);
      check("R12 reset dyn_addr", dyn_addr, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 idle after reset", rsp_valid, 0);

      // R1 static match before assignment
      hdr(STAT, 1'b0, a); check("R1 static ack", a, 1);
      check("R12 rsp_valid after event", rsp_valid, 1);
      stp();
      @(negedge clk); check("R12 rsp_valid clears", rsp_valid, 0);
      hdr(7'h2B, 1'b0, a); check("R1 other nack", a, 0); stp();

      // R11 private read returns idle byte
      hdr(STAT, 1'b1, a); rd(d); check("R11 private read", d, 8'hFF); stp();

      // R2 R8 R9 GETBCR with repeated starts
      hdr(7'h7E, 1'b0, a); check("R2 bcast ack", a, 1);
      wr(8'h8E, a); check("R2 code ack", a, 1);
      hdr(STAT, 1'b1, a); check("R8 direct hdr ack", a, 1);
      rd(d); check("R8 bchr", d, BCV);
      hdr(STAT, 1'b1, a); rd(d); check("R9 direct Sr keeps command", d, BCV);
      hdr(7'h7E, 1'b1, a); check("R9 bcast Sr ack", a, 1);
      rd(d); check("R9 bcast Sr ends command", d, 8'hFF);
      stp();

      // R8 GETDCR
      hdr(7'h7E, 1'b0, a); wr(8'h8F, a); hdr(STAT, 1'b1, a); rd(d);
      check("R8 dchr", d, DCV); stp();

      // R8 GETPID
      hdr(7'h7E, 1'b0, a); wr(8'h8D, a); hdr(STAT, 1'b1, a);
      for (int i = 0; i < 6; i++) begin
         rd(d); check("R8 pid byte", d, pid_byte(i));
      end
      rd(d); check("R8 pid past end", d, 8'hFF); stp();

      // R10 R11 unsupported commands
      hdr(7'h7E, 1'b0, a); wr(8'h9A, a); hdr(STAT, 1'b0, a);
      wr(8'h11, a); check("R10 direct unsupported nack", a, 0); stp();
      check("R11 unsupported keeps addr", dyn_addr, 0);
      hdr(7'h7E, 1'b0, a); wr(8'h1F, a); wr(8'h22, a);
      check("R10 bcast unsupported ack", a, 1); stp();
      check("R11 bcast unsupported keeps addr", dyn_addr, 0);

      // R11 unselected read
      hdr(7'h33, 1'b1, a); check("R11 unselected nack", a, 0);
      rd(d); check("R11 unselected read", d, 8'hFF); stp();

      // R3 R4 R5 address assignment
      hdr(7'h7E, 1'b0, a); wr(8'h07, a); check("R2 daa code ack", a, 1);
      hdr(7'h7E, 1'b1, a); check("R3 daa bcast ack", a, 1);
      for (int i = 0; i < 6; i++) begin
         rd(d); check("R4 daa pid", d, pid_byte(i));
      end
      rd(d); check("R4 daa bchr", d, BCV);
      rd(d); check("R4 daa dchr", d, DCV);
      rd(d); check("R4 daa past end", d, 8'hFF);
      wr(8'hB1, a); check("R5 assign ack", a, 1);
      check("R5 dyn assigned", dyn_addr, 7'h31);
      hdr(7'h7E, 1'b1, a); check("R5 assigned bcast nack", a, 0);
      hdr(7'h31, 1'b0, a); check("R3 daa direct nack", a, 0);
      stp();
      hdr(7'h31, 1'b0, a); check("R1 dyn ack", a, 1); stp();
      hdr(STAT, 1'b0, a); check("R1 static ignored", a, 0); stp();

      // R6 clear and copy-from-static
      hdr(7'h7E, 1'b0, a); wr(8'h06, a); stp();
      check("R6 clear", dyn_addr, 0);
      hdr(7'h7E, 1'b0, a); wr(8'h29, a); stp();
      check("R6 all static", dyn_addr, STAT);
      hdr(7'h7E, 1'b0, a); wr(8'h06, a); stp();

      // R7 direct static and new address
      hdr(7'h7E, 1'b0, a); wr(8'h87, a); hdr(STAT, 1'b0, a);
      wr(8'h54, a); check("R7 one static ack", a, 1); stp();
      check("R7 one static", dyn_addr, STAT);
      hdr(7'h7E, 1'b0, a); wr(8'h88, a); hdr(STAT, 1'b0, a);
      wr(8'h40, a); stp();
      check("R7 new addr", dyn_addr, 7'h40);

      // R1 R7 random new addresses and probes
      cur = 7'h40;
      for (int k = 0; k < 40; k++) begin
         logic [6:0] nxt;
         logic [6:0] probe;
         nxt = 7'(($urandom() % 32'h7D) + 1);
         hdr(7'h7E, 1'b0, a); wr(8'h88, a); hdr(cur, 1'b0, a);
         wr({1'b0, nxt}, a); stp();
         cur = nxt;
         check("R7 random new addr", dyn_addr, cur);
         probe = 7'($urandom() % 32'h7E);
         if (k % 4 == 0) probe = cur;
         hdr(probe, 1'b0, a); stp();
         check("R1 random probe", a, exp_hit(probe, cur));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule